// File: doc/BRIEF.md
# Port-Decoded Reset and Status Flags

This block is the control glue of a peripheral card on an 8-bit bus with a separate I/O address space. It watches I/O reads and writes on two port addresses. It builds one active-low reset for the whole card. That reset has three possible causes: a local power-on input, a host-side reset line, and a software write to a reset port. The write data plays no part in the reset, so the block has no write-data input at all.

The block holds two single-bit state cells. The first is a set/clear latch driven by two active-low inputs, with clear taking priority. Software reads its state at the reset port address. The second is a handshake flag with these rules:
- An active-low request sets it.
- A falling edge on a strobe clears it, because the strobe can only load a zero.
- The card reset forces it to zero. Clear has priority over set, and set has priority over the strobe.

The flag is returned in a status byte read from a second port, and it also enables the data-out line drivers.

All logic runs on one system clock. Every asynchronous input passes through a two-flop synchronizer first. Read responses are a one-way stream: `rd_valid` pulses for one clock with `rd_data`, and there is no back-pressure, so the bus side must accept the byte in that cycle.

Top module: `card_ctl`

## Requirements
- R1: While `pwr_rst_n` is low, `card_rst_n` is low, `drv_en` is low, `rd_valid` is low and the latch is 0.
- R2: When `host_rst_n` is held low for at least 3 clocks, `card_rst_n` goes low. `card_rst_n` returns high within 4 clocks after `host_rst_n` rises, unless another reset cause is active.
- R3: A write (`io_wr` high for one clock) to address 0x40 drives `card_rst_n` low for exactly 4 clocks (parameter STRETCH). The low period starts at the second rising edge after the write edge.
- R4: A write to any address other than 0x40, including 0x78, leaves `card_rst_n` high.
- R5: A read (`io_rd` high for one clock) of address 0x40 or 0x78 gives `rd_valid` high for exactly the following clock, with the response byte on `rd_data`.
- R6: The latch becomes 1 when `srl_set_n` is low and 0 when `srl_clr_n` is low. It becomes 0 when both are low, and it holds its value when both are high. A read of 0x40 returns the latch in bit 0 and 0 in bits 7:1. A card reset caused by software does not change the latch.
- R7: A low level on `hs_req_n` sets the handshake flag. A falling edge on `hs_stb` clears the flag, unless `hs_req_n` is low at the same time, in which case the flag stays 1.
- R8: A low `card_rst_n` clears the flag. It wins over a low `hs_req_n`, and the flag can only become 1 after `card_rst_n` is high again.
- R9: A read of 0x78 returns the flag in bit 1 (mask 0x02), with all other bits 0.
- R10: A read of any address other than 0x40 and 0x78 leaves `rd_valid` low and `rd_data` at 0x00.
- R11: `drv_en` always equals the handshake flag that is reported in bit 1 of the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_rst_n | input | 1 | Local power-on reset, active low, asynchronous assert |
| host_rst_n | input | 1 | Host-side reset line, active low, asynchronous |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe, one clock per access |
| io_rd | input | 1 | I/O read strobe, one clock per access |
| rd_valid | output | 1 | Read response valid for one clock |
| rd_data | output | 8 | Read response byte, 0 when not valid |
| srl_set_n | input | 1 | Latch set, active low, asynchronous |
| srl_clr_n | input | 1 | Latch clear, active low, asynchronous |
| hs_stb | input | 1 | Handshake strobe; a falling edge clears the flag |
| hs_req_n | input | 1 | Handshake request, active low; sets the flag |
| card_rst_n | output | 1 | Card-wide reset, active low |
| drv_en | output | 1 | Data-out line driver enable |

## Verification
The hardest case to reach is a collision of priorities on the handshake flag. In one case the request is held low while the card reset is active. In the other the strobe falls while the request is still low. Both need asynchronous inputs aligned across the synchronizer delay. The stimulus holds the request low for many clocks and then raises the competing cause inside that window. It checks the flag both during the overlap and after each cause is released. The software reset is also issued while the latch is 1, to show that the stretched reset clears the flag and leaves the latch alone.

// File: rtl/card_ctl_pkg.sv
package card_ctl_pkg;
  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_LATCH  = 2'd1,
    RSEL_STATUS = 2'd2
  } rsel_e;
endpackage

// File: rtl/card_sync.sv
module card_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage[s] <= RST_VAL;
        else         stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage[s] <= RST_VAL;
        else         stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/card_rst_ctl.sv
module card_rst_ctl #(
  parameter int STRETCH = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic host_ok_n,
  input  logic sw_hit,
  output logic card_rst_n
);
  localparam int CNT_W = $clog2(STRETCH + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH);

  logic [CNT_W-1:0] cnt;
  logic             card_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt    <= '0;
      card_q <= 1'b0;
    end else begin
      if (sw_hit)           cnt <= LOAD;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
      card_q <= host_ok_n && (cnt == '0);
    end
  end

  assign card_rst_n = card_q;
endmodule

// File: rtl/card_flag_cell.sv
module card_flag_cell #(
  parameter bit HAS_STROBE = 1'b1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr_n,
  input  logic set_n,
  input  logic stb_fall,
  output logic q
);
  localparam logic STB_EN = HAS_STROBE;
  logic load0;

  assign load0 = STB_EN & stb_fall;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     q <= RST_VAL;
    else if (!clr_n) q <= 1'b0;
    else if (!set_n) q <= 1'b1;
    else if (load0)  q <= 1'b0;
  end
endmodule

// File: rtl/card_rd_port.sv
module card_rd_port
  import card_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] LATCH_PORT = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_PORT = 8'h78,
  parameter int FLAG_BIT = 1
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              io_rd,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              latch_q,
  input  logic              flag_q,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  rsel_e             sel;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    sel = RSEL_NONE;
    if (io_rd && io_addr == LATCH_PORT)     sel = RSEL_LATCH;
    else if (io_rd && io_addr == STAT_PORT) sel = RSEL_STATUS;
  end

  always_comb begin
    nxt = '0;
    case (sel)
      RSEL_LATCH:  nxt[0] = latch_q;
      RSEL_STATUS: nxt[FLAG_BIT] = flag_q;
      default:     nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= (sel != RSEL_NONE);
      rd_data  <= nxt;
    end
  end
endmodule

// File: rtl/card_ctl.sv
module card_ctl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RST_PORT = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_PORT = 8'h78,
  parameter int FLAG_BIT = 1,
  parameter int STRETCH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              host_rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              srl_set_n,
  input  logic              srl_clr_n,
  input  logic              hs_stb,
  input  logic              hs_req_n,
  output logic              card_rst_n,
  output logic              drv_en
);
  localparam int NSYNC = 5;
  // bit order: host, set, clr, strobe, request; host resets asserted, rest idle high
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b01111;

  logic [NSYNC-1:0] raw, syn;
  logic host_s_n, set_s_n, clr_s_n, stb_s, req_s_n;
  logic stb_d, stb_fall, sw_hit, latch_q, flag_q;

  assign raw = {host_rst_n, srl_set_n, srl_clr_n, hs_stb, hs_req_n};
  assign {host_s_n, set_s_n, clr_s_n, stb_s, req_s_n} = syn;

  card_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .arst_n(pwr_rst_n), .d(raw), .q(syn)
  );

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) stb_d <= 1'b1;
    else            stb_d <= stb_s;
  end
  assign stb_fall = stb_d & ~stb_s;

  assign sw_hit = io_wr && (io_addr == RST_PORT);

  card_rst_ctl #(.STRETCH(STRETCH)) u_rst (
    .clk(clk), .arst_n(pwr_rst_n), .host_ok_n(host_s_n),
    .sw_hit(sw_hit), .card_rst_n(card_rst_n)
  );

  card_flag_cell #(.HAS_STROBE(1'b0), .RST_VAL(1'b0)) u_latch (
    .clk(clk), .arst_n(pwr_rst_n), .clr_n(clr_s_n), .set_n(set_s_n),
    .stb_fall(1'b0), .q(latch_q)
  );

  card_flag_cell #(.HAS_STROBE(1'b1), .RST_VAL(1'b0)) u_flag (
    .clk(clk), .arst_n(pwr_rst_n), .clr_n(card_rst_n), .set_n(req_s_n),
    .stb_fall(stb_fall), .q(flag_q)
  );

  assign drv_en = flag_q;

  card_rd_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATCH_PORT(RST_PORT),
    .STAT_PORT(STAT_PORT), .FLAG_BIT(FLAG_BIT)
  ) u_rd (
    .clk(clk), .arst_n(pwr_rst_n), .io_rd(io_rd), .io_addr(io_addr),
    .latch_q(latch_q), .flag_q(flag_q), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/card_ctl_chk.sv
module card_ctl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] RST_PORT = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_PORT = 8'h78
) (
  input logic              clk,
  input logic              pwr_rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              card_rst_n,
  input logic              drv_en
);
  // R1
  always_comb begin
    if (!pwr_rst_n) begin
      a_pwr_hold_r1: assert (!card_rst_n && !drv_en && !rd_valid);
    end
  end

  p_sw_stretch_r3: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (io_wr && io_addr == RST_PORT) |-> ##2 !card_rst_n ##1 !card_rst_n
                                       ##1 !card_rst_n ##1 !card_rst_n);

  p_rd_valid_r5: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rd_valid |-> $past(io_rd && (io_addr == RST_PORT || io_addr == STAT_PORT)));

  p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rd_valid |-> (rd_data[DATA_W-1:2] == '0 && !(rd_data[0] && rd_data[1])));

  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !rd_valid |-> rd_data == '0);

  p_rst_clears_r8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !card_rst_n |=> !drv_en);

  p_set_after_rst_r8: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    $rose(drv_en) |-> $past(card_rst_n));
endmodule

bind card_ctl card_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_PORT(RST_PORT), .STAT_PORT(STAT_PORT)
) u_chk (
  .clk(clk), .pwr_rst_n(pwr_rst_n), .io_addr(io_addr), .io_wr(io_wr),
  .io_rd(io_rd), .rd_valid(rd_valid), .rd_data(rd_data),
  .card_rst_n(card_rst_n), .drv_en(drv_en)
);

// File: tb/sim_card_ctl.sv
`timescale 1ns/1ps
module sim_card_ctl;
  logic clk = 1'b0;
  logic pwr_rst_n = 1'b0, host_rst_n = 1'b1;
  logic [7:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic srl_set_n = 1'b1, srl_clr_n = 1'b1, hs_stb = 1'b1, hs_req_n = 1'b1;
  logic card_rst_n, drv_en;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] expq[$];
  string tagq[$];

  always #2.5 clk = ~clk;

  card_ctl u0 (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .host_rst_n(host_rst_n),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .srl_set_n(srl_set_n), .srl_clr_n(srl_clr_n),
    .hs_stb(hs_stb), .hs_req_n(hs_req_n),
    .card_rst_n(card_rst_n), .drv_en(drv_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes expected bytes, monitor pops them
  task automatic rd_port(input logic [7:0] a, input logic hit, input logic [7:0] exp,
                         input string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    if (hit) begin expq.push_back(exp); tagq.push_back(tag); end
    @(negedge clk);
    io_rd = 1'b0;
    if (!hit) begin
      chk({tag, " rd_valid"}, {7'b0, rd_valid}, 8'h00);
      chk({tag, " rd_data"}, rd_data, 8'h00);
    end
  endtask

  task automatic wr_count_low(input logic [7:0] a, output int lows);
    @(negedge clk);
    io_addr = a; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    lows = 0;
    repeat (10) begin
      @(negedge clk);
      if (!card_rst_n) lows++;
    end
  endtask

  task automatic pulse_low(ref logic s, input int n);
    @(negedge clk); s = 1'b0;
    idle(n);
    s = 1'b1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (pwr_rst_n && rd_valid) begin
      if (expq.size() == 0) begin
        chk("R5 unexpected rd_valid", 8'h01, 8'h00);
      end else begin
        chk(tagq.pop_front(), rd_data, expq.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int lows;
    idle(3);
    // R1 reset state
    chk("R1 card_rst_n", {7'b0, card_rst_n}, 8'h00);
    chk("R1 drv_en", {7'b0, drv_en}, 8'h00);
    chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    pwr_rst_n = 1'b1;
    idle(6);
    chk("R2 release", {7'b0, card_rst_n}, 8'h01);
    rd_port(8'h78, 1'b1, 8'h00, "R9 status after reset");
    rd_port(8'h40, 1'b1, 8'h00, "R1 latch after reset");

    // R7 request sets flag
    pulse_low(hs_req_n, 3);
    idle(4);
    chk("R11 drv_en set", {7'b0, drv_en}, 8'h01);
    rd_port(8'h78, 1'b1, 8'h02, "R9 status flag=1");

    // R7 strobe fall clears
    @(negedge clk); hs_stb = 1'b0;
    idle(5);
    chk("R7 strobe clears", {7'b0, drv_en}, 8'h00);
    rd_port(8'h78, 1'b1, 8'h00, "R9 status flag=0");
    hs_stb = 1'b1; idle(4);

    // R7 request held low over strobe fall
    @(negedge clk); hs_req_n = 1'b0;
    idle(4);
    hs_stb = 1'b0;
    idle(5);
    chk("R7 request beats strobe", {7'b0, drv_en}, 8'h01);
    hs_req_n = 1'b1;
    idle(5);
    chk("R7 no new edge", {7'b0, drv_en}, 8'h01);
    hs_stb = 1'b1; idle(4);

    // R6 latch
    pulse_low(srl_set_n, 3); idle(4);
    rd_port(8'h40, 1'b1, 8'h01, "R6 latch set");
    idle(3);
    rd_port(8'h40, 1'b1, 8'h01, "R6 latch hold");
    pulse_low(srl_clr_n, 3); idle(4);
    rd_port(8'h40, 1'b1, 8'h00, "R6 latch clear");
    @(negedge clk); srl_set_n = 1'b0; idle(4);
    srl_clr_n = 1'b0; idle(4);
    rd_port(8'h40, 1'b1, 8'h00, "R6 both low clear wins");
    srl_clr_n = 1'b1; idle(4);
    srl_set_n = 1'b1; idle(4);
    rd_port(8'h40, 1'b1, 8'h01, "R6 latch set again");

    // R4 writes elsewhere
    wr_count_low(8'h78, lows);
    chk("R4 write 0x78", 8'(lows), 8'd0);
    wr_count_low(8'h41, lows);
    chk("R4 write 0x41", 8'(lows), 8'd0);
    chk("R4 flag kept", {7'b0, drv_en}, 8'h01);

    // R3 software reset
    wr_count_low(8'h40, lows);
    chk("R3 stretch length", 8'(lows), 8'd4);
    chk("R8 sw reset clears flag", {7'b0, drv_en}, 8'h00);
    rd_port(8'h40, 1'b1, 8'h01, "R6 latch survives sw reset");

    // R8 clear wins over request, R2 host reset
    @(negedge clk); hs_req_n = 1'b0; idle(5);
    chk("R7 set before host reset", {7'b0, drv_en}, 8'h01);
    host_rst_n = 1'b0; idle(5);
    chk("R2 host reset asserts", {7'b0, card_rst_n}, 8'h00);
    chk("R8 clear beats request", {7'b0, drv_en}, 8'h00);
    rd_port(8'h78, 1'b1, 8'h00, "R8 status during reset");
    host_rst_n = 1'b1; idle(5);
    chk("R2 host reset released", {7'b0, card_rst_n}, 8'h01);
    chk("R8 request after reset", {7'b0, drv_en}, 8'h01);
    hs_req_n = 1'b1; idle(3);

    // R10 misses
    rd_port(8'h00, 1'b0, 8'h00, "R10 addr 0x00");
    rd_port(8'h79, 1'b0, 8'h00, "R10 addr 0x79");
    rd_port(8'h3F, 1'b0, 8'h00, "R10 addr 0x3F");
    rd_port(8'h78, 1'b1, 8'h02, "R9 status final");
    idle(3);
    chk("R5 all responses seen", 8'(expq.size()), 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule